// File: doc/BRIEF.md
# Mode-selectable synchronous clock divider tree

The block turns one fast master clock into a set of divided clock outputs for a PC-style board: a CPU clock, a half-CPU clock, a fixed 66 MHz clock, a 33 MHz PCI clock and a 16.67 MHz APIC clock. With the default 400 MHz master, one select input puts the CPU clock at 133 MHz (divide by 3) or at 100 MHz (divide by 4). The half-CPU clock follows the CPU clock. The 66, 33 and 16.67 MHz outputs keep their divide ratios in both modes.

All dividers count inside a common 24-cycle frame, and every frame starts with each divider at count zero. Every output therefore rises on the same master edge at the start of each frame. The select input is taken only at the edge that closes a frame, so a change of mode never shortens a pulse. Each group of outputs is driven from one register, so the outputs in a group always match. Each output is high for the first floor(N/2) master cycles of its N-cycle period.

Top module: `clk_div_tree`

## Requirements
- R1: While rst_ni is low every output is high. After release the block runs in 133 mode until the first frame boundary, whatever mode_133_i is.
- R2: Let k be the number of master rising edges since reset release, and p = k mod 24. In 133 mode (mode_133_i=1) cpu_o is high when (p mod 3) < 1. In 100 mode (mode_133_i=0) cpu_o is high when (p mod 4) < 2.
- R3: In 133 mode cpu_half_o is high when (p mod 6) < 3. In 100 mode it is high when (p mod 8) < 4.
- R4: In both modes fix66_o is high when (p mod 6) < 3.
- R5: In both modes pci_o is high when (p mod 12) < 6.
- R6: In both modes apic_o is high when p < 12.
- R7: mode_133_i is sampled only on rising edges with k a multiple of 24, k>0. That value sets the mode for the following 24 cycles. A change of mode_133_i at any other time has no effect on the outputs.
- R8: At every frame start (p=0) all outputs are high together. No output has a high or low time other than those given in R2 to R6, including across a mode change.
- R9: There are 4 cpu_o, 2 cpu_half_o, 4 fix66_o, 8 pci_o and 3 apic_o bits, and all bits of a group carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (400 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_133_i | input | 1 | 1 selects 133 MHz CPU mode, 0 selects 100 MHz mode |
| cpu_o | output | 4 | CPU clock group |
| cpu_half_o | output | 2 | Half-CPU clock group |
| fix66_o | output | 4 | Fixed 66 MHz group |
| pci_o | output | 8 | 33 MHz PCI group |
| apic_o | output | 3 | 16.67 MHz APIC group |

## Verification
The assertions assume only that mode_133_i settles before each master edge. They do not assume that it is held steady within a frame, because the block is required to ignore changes mid-frame. The stimulus drives the select away from the clock edge from a seeded random source. That source alternates between toggling every cycle, holding the select for several frames, and flipping it only near frame boundaries. Every frame boundary therefore sees both a change of mode and no change.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int FRAME_LEN_DEF = 24;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_width(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/clk_frame_ctrl.sv
module clk_frame_ctrl #(
  parameter int FRAME_LEN = clk_div_pkg::FRAME_LEN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_133_i,
  output logic mode_o,
  output logic restart_o
);
  localparam int FW = clk_div_pkg::cnt_width(FRAME_LEN);
  localparam logic [FW-1:0] LAST = FW'(FRAME_LEN - 1);

  logic [FW-1:0] fcnt_q;
  logic          mode_q;
  logic          wrap;

  assign wrap = (fcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      mode_q <= 1'b1;
    end else begin
      fcnt_q <= wrap ? '0 : fcnt_q + 1'b1;
      // mode is only taken at the frame boundary
      if (wrap) mode_q <= mode_133_i;
    end
  end

  assign mode_o    = mode_q;
  assign restart_o = wrap;
endmodule

// File: rtl/clk_div_cell.sv
module clk_div_cell #(
  parameter int DIV_A = 3,
  parameter int DIV_B = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_a_i,
  input  logic restart_i,
  output logic clk_o
);
  localparam int MAXD = clk_div_pkg::max2(DIV_A, DIV_B);
  localparam int CW   = clk_div_pkg::cnt_width(MAXD);
  localparam logic [CW-1:0] A_LAST = CW'(DIV_A - 1);
  localparam logic [CW-1:0] B_LAST = CW'(DIV_B - 1);
  localparam logic [CW-1:0] A_HALF = CW'(DIV_A / 2);
  localparam logic [CW-1:0] B_HALF = CW'(DIV_B / 2);

  logic [CW-1:0] cnt_q, cnt_nxt, last, half;
  logic          out_q;

  generate
    if (DIV_A == DIV_B) begin : g_fixed
      assign last = A_LAST;
      assign half = A_HALF;
      logic unused_sel;
      assign unused_sel = sel_a_i;
    end else begin : g_sel
      assign last = sel_a_i ? A_LAST : B_LAST;
      assign half = sel_a_i ? A_HALF : B_HALF;
    end
  endgenerate

  always_comb begin
    if (restart_i || cnt_q == last) cnt_nxt = '0;
    else                            cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      out_q <= (cnt_nxt < half);
    end
  end

  assign clk_o = out_q;
endmodule

// File: rtl/clk_div_tree.sv
module clk_div_tree #(
  parameter int FRAME_LEN  = 24,
  parameter int CPU_FAST   = 3,
  parameter int CPU_SLOW   = 4,
  parameter int F66_DIV    = 6,
  parameter int PCI_DIV    = 12,
  parameter int APIC_DIV   = 24,
  parameter int N_CPU      = 4,
  parameter int N_HALF     = 2,
  parameter int N_F66      = 4,
  parameter int N_PCI      = 8,
  parameter int N_APIC     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_133_i,
  output logic [N_CPU-1:0]  cpu_o,
  output logic [N_HALF-1:0] cpu_half_o,
  output logic [N_F66-1:0]  fix66_o,
  output logic [N_PCI-1:0]  pci_o,
  output logic [N_APIC-1:0] apic_o
);
  localparam int NDIV = 5;
  localparam int DA [NDIV] = '{CPU_FAST, 2*CPU_FAST, F66_DIV, PCI_DIV, APIC_DIV};
  localparam int DB [NDIV] = '{CPU_SLOW, 2*CPU_SLOW, F66_DIV, PCI_DIV, APIC_DIV};

  logic            mode;
  logic            restart;
  logic [NDIV-1:0] div_clk;

  clk_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_133_i(mode_133_i),
    .mode_o    (mode),
    .restart_o (restart)
  );

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    clk_div_cell #(.DIV_A(DA[i]), .DIV_B(DB[i])) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_a_i  (mode),
      .restart_i(restart),
      .clk_o    (div_clk[i])
    );
  end

  assign cpu_o      = {N_CPU{div_clk[0]}};
  assign cpu_half_o = {N_HALF{div_clk[1]}};
  assign fix66_o    = {N_F66{div_clk[2]}};
  assign pci_o      = {N_PCI{div_clk[3]}};
  assign apic_o     = {N_APIC{div_clk[4]}};
endmodule

// File: rtl/clk_div_tree_chk.sv
module clk_div_tree_chk #(
  parameter int N_CPU  = 4,
  parameter int N_HALF = 2,
  parameter int N_F66  = 4,
  parameter int N_PCI  = 8,
  parameter int N_APIC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CPU-1:0]  cpu_o,
  input logic [N_HALF-1:0] cpu_half_o,
  input logic [N_F66-1:0]  fix66_o,
  input logic [N_PCI-1:0]  pci_o,
  input logic [N_APIC-1:0] apic_o
);
  // R9
  group_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_o == '0 || &cpu_o) && (cpu_half_o == '0 || &cpu_half_o) &&
    (fix66_o == '0 || &fix66_o) && (pci_o == '0 || &pci_o) &&
    (apic_o == '0 || &apic_o));

  // R4
  f66_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fix66_o[0]) |=> fix66_o[0] ##1 fix66_o[0] ##1 !fix66_o[0]);

  // R2
  cpu_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_o[0] && $past(cpu_o[0]) |=> !cpu_o[0]);

  // R8
  apic_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(apic_o[0]) |-> cpu_o[0] && cpu_half_o[0] && fix66_o[0] && pci_o[0]);

  // R5
  pci_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_o[0]) |-> cpu_o[0] && fix66_o[0]);
endmodule

bind clk_div_tree clk_div_tree_chk #(
  .N_CPU(N_CPU), .N_HALF(N_HALF), .N_F66(N_F66), .N_PCI(N_PCI), .N_APIC(N_APIC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpu_o     (cpu_o),
  .cpu_half_o(cpu_half_o),
  .fix66_o   (fix66_o),
  .pci_o     (pci_o),
  .apic_o    (apic_o)
);

// File: tb/clk_div_tree_test.sv
`timescale 1ns/1ps
module clk_div_tree_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_133_i = 1'b0;
  logic [3:0] cpu_o;
  logic [1:0] cpu_half_o;
  logic [3:0] fix66_o;
  logic [7:0] pci_o;
  logic [2:0] apic_o;

  int errors = 0;
  int checks = 0;
  int k = 0;
  logic fmode = 1'b1;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  clk_div_tree uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_133_i(mode_133_i),
    .cpu_o(cpu_o), .cpu_half_o(cpu_half_o), .fix66_o(fix66_o),
    .pci_o(pci_o), .apic_o(apic_o)
  );

  function automatic logic hi(int p, int n);
    return (p % n) < (n / 2);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s k=%0d actual=%h expected=%h", req, k, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int p = k % 24;
    logic c  = hi(p, fmode ? 3 : 4);
    logic h  = hi(p, fmode ? 6 : 8);
    check({tag, " R2 cpu"},  {4'b0, cpu_o},      {4'b0, {4{c}}});
    check({tag, " R3 half"}, {6'b0, cpu_half_o}, {6'b0, {2{h}}});
    check({tag, " R4 f66"},  {4'b0, fix66_o},    {4'b0, {4{hi(p, 6)}}});
    check({tag, " R5 pci"},  pci_o,              {8{hi(p, 12)}});
    check({tag, " R6 apic"}, {5'b0, apic_o},     {5'b0, {3{hi(p, 24)}}});
    if (p == 0)
      check({tag, " R8 align"}, {3'b0, cpu_o[0], cpu_half_o[0], fix66_o[0], pci_o[0], apic_o[0]},
            8'h1f);
  endtask

  // one master cycle: check at negedge, then drive the select for the next edge
  task automatic step(logic m, string tag);
    check_all(tag);
    mode_133_i = m;
    @(posedge clk_i);
    k++;
    if (k % 24 == 0) fmode = mode_133_i;
    @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: outputs high during reset regardless of select
    repeat (3) begin
      @(negedge clk_i);
      mode_133_i = 1'($urandom);
      check("R1 reset", {3'b0, cpu_o[0], cpu_half_o[0], fix66_o[0], pci_o[0], apic_o[0]}, 8'h1f);
      check("R9 reset", {&cpu_o, &cpu_half_o, &fix66_o, &pci_o, &apic_o, 3'b0}, 8'hf8);
    end
    // R1: select low at release, first frame still in 133 mode
    mode_133_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 24; i++) step(1'b0, "R1 first");
    // R7: held 100 mode for several frames
    for (int i = 0; i < 72; i++) step(1'b0, "R7 hold100");
    // R7: toggle every cycle, mode follows only the boundary sample
    for (int i = 0; i < 240; i++) step(1'(i & 1), "R7 toggle");
    // R7: flip only around boundaries
    for (int i = 0; i < 480; i++) step(((k + 1) % 24 == 0) ? ~fmode : fmode, "R7 edge");
    // random segments
    for (int s = 0; s < 40; s++) begin
      int len = 10 + int'($urandom_range(80));
      int kind = int'($urandom_range(2));
      logic m = 1'($urandom);
      for (int i = 0; i < len; i++) begin
        if (kind == 0) m = 1'($urandom);
        else if (kind == 1 && $urandom_range(30) == 0) m = ~m;
        step(m, "R8 rand");
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog k=%0d actual=hung expected=done", k);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule